// File: doc/BRIEF.md
# Interrupt Nesting Level Gate

This block sits between a bank of system interrupt lines and one host interrupt line. Each system line is watched for a rising edge, which latches a status bit. Status bits that are also enabled become candidates, and a resolver picks the most urgent candidate. A lower priority value is more urgent, and the lower index wins a tie. The host line is raised only when that winner beats the current nesting level. A nested handler can therefore raise the level so that only more urgent sources can preempt it.

Software reaches the block through a plain single-cycle register port. Writes take effect on the clock edge and reads are combinational from the address. The port also clears status, either with a write-one-to-clear bitmask or by writing one source index. The nesting register has an override flag. With the flag clear it reports the priority of the current winner and leaves the gate open. With the flag set it holds a software level and gates against it. None of the pins carries a data stream, so every pin is a plain level with no handshake or back-pressure.

Register map, word addresses:
- 0: control. Bit 0 is the host enable.
- 1: source enable mask.
- 2: status. A read returns the raw status and a write of 1 clears that bit.
- 3: index clear.
- 4: nesting. Bit 15 is the override flag and bits [PRIO_W-1:0] hold the level.
- 8+i: priority of source i.

Top module: `intr_nest_gate`

## Requirements
- R1: A status bit is set at the clock edge that samples its `sys_irq` line high after sampling it low. The line is low in reset. A line held high does not set the bit again after a clear.
- R2: A write to address 2 clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. A read of address 2 returns the status vector.
- R3: A write of value k to address 3 clears status bit k when k < NUM_SRC. Values of NUM_SRC or more change nothing.
- R4: A clear by either method in the same cycle as a new rising edge on that source leaves the status bit set.
- R5: Only bits that are set in both status and the enable mask at address 1 are candidates. Clearing an enable bit does not change status.
- R6: `active_valid` is high when any candidate exists. `active_idx` and `active_prio` give the candidate with the lowest priority value, and the lowest index wins a tie. With no candidate they read 0 and all-ones.
- R7: With override clear (bit 15 = 0), a read of address 4 returns the priority of the current winner, or all-ones when there is none. The gate passes any winner.
- R8: A write to address 4 with bit 15 set stores the level from bits [PRIO_W-1:0], and a read returns bit 15 together with that level. `host_irq` is then high only when `active_prio` is strictly less than the level. A write with bit 15 clear clears the override.
- R9: `host_irq` requires bit 0 of address 0 to be set. Clearing that bit drops `host_irq` without changing status.
- R10: After reset, status, enables, priorities, host enable and override are all 0, and `host_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_irq | input | NUM_SRC | System interrupt lines, edge detected |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr, combinational |
| host_irq | output | 1 | Gated host interrupt |
| active_valid | output | 1 | A candidate exists |
| active_idx | output | $clog2(NUM_SRC) | Index of the winning candidate |
| active_prio | output | PRIO_W | Priority of the winning candidate |

## Verification
A wrong status bit shows up on the cycle after the edge or the write that caused it. It appears at the `active_*` outputs and in the status read. A wrong tie-break or comparison shows directly as the wrong `active_idx` or `host_irq` for that pattern, so the stimulus table mixes ties, disabled sources and levels on both sides of the winner's priority. A stuck override or a stuck level shows in the nesting read and in `host_irq` on the same cycle as the register change.

// File: rtl/ing_pkg.sv
package ing_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int OVR_BIT = 15;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE = 5'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 5'd2;
  localparam logic [ADDR_W-1:0] A_IDXCLR = 5'd3;
  localparam logic [ADDR_W-1:0] A_NEST   = 5'd4;
  localparam int                PRIO_BASE = 8;
endpackage

// File: rtl/ing_status.sv
module ing_status #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] sys_irq,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] status
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] rise;

  // A new edge takes precedence over a clear in the same cycle.
  assign rise = sys_irq & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      status <= '0;
    end else begin
      prev_q <= sys_irq;
      status <= (status & ~clr_mask) | rise;
    end
  end
endmodule

// File: rtl/ing_regs.sv
module ing_regs
  import ing_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic                      host_en,
  output logic [NUM_SRC-1:0]        enable,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      nest_ovr,
  output logic [PRIO_W-1:0]         nest_lvl,
  output logic [NUM_SRC-1:0]        clr_mask
);
  logic [NUM_SRC-1:0] idx_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_en  <= 1'b0;
      enable   <= '0;
      nest_ovr <= 1'b0;
      nest_lvl <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL)   host_en <= wdata[0];
      if (addr == A_ENABLE) enable  <= wdata[NUM_SRC-1:0];
      if (addr == A_NEST) begin
        nest_ovr <= wdata[OVR_BIT];
        nest_lvl <= wdata[PRIO_W-1:0];
      end
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_flat[i*PRIO_W +: PRIO_W] <= '0;
      else if (wr_en && addr == ADDR_W'(PRIO_BASE + i))
        prio_flat[i*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
    end
    assign idx_hit[i] = wr_en && (addr == A_IDXCLR) &&
                        (wdata == DATA_W'(i));
  end

  always_comb begin
    clr_mask = idx_hit;
    if (wr_en && addr == A_STATUS)
      clr_mask = clr_mask | wdata[NUM_SRC-1:0];
  end
endmodule

// File: rtl/ing_pick.sv
module ing_pick #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      valid,
  output logic [IDX_W-1:0]          idx,
  output logic [PRIO_W-1:0]         prio
);
  logic [PRIO_W-1:0] p [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_unpack
    assign p[i] = prio_flat[i*PRIO_W +: PRIO_W];
  end

  // Strict less-than while scanning upward keeps the lowest index on ties.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    prio  = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!valid || p[i] < prio)) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
        prio  = p[i];
      end
    end
  end
endmodule

// File: rtl/intr_nest_gate.sv
module intr_nest_gate
  import ing_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] sys_irq,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               host_irq,
  output logic               active_valid,
  output logic [IDX_W-1:0]   active_idx,
  output logic [PRIO_W-1:0]  active_prio
);
  logic                      host_en;
  logic [NUM_SRC-1:0]        enable_q;
  logic [NUM_SRC-1:0]        status_q;
  logic [NUM_SRC-1:0]        clr_mask;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                      nest_ovr;
  logic [PRIO_W-1:0]         nest_lvl;
  logic [PRIO_W:0]           gate_lvl;

  ing_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .host_en(host_en), .enable(enable_q),
    .prio_flat(prio_flat), .nest_ovr(nest_ovr), .nest_lvl(nest_lvl),
    .clr_mask(clr_mask)
  );

  ing_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk(clk), .rst_n(rst_n), .sys_irq(sys_irq),
    .clr_mask(clr_mask), .status(status_q)
  );

  ing_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
    .cand(status_q & enable_q), .prio_flat(prio_flat),
    .valid(active_valid), .idx(active_idx), .prio(active_prio)
  );

  // Without override the threshold sits above every priority: gate open.
  assign gate_lvl = nest_ovr ? {1'b0, nest_lvl} : {1'b1, {PRIO_W{1'b0}}};
  assign host_irq = host_en && active_valid && ({1'b0, active_prio} < gate_lvl);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL:   reg_rdata[0] = host_en;
      A_ENABLE: reg_rdata[NUM_SRC-1:0] = enable_q;
      A_STATUS: reg_rdata[NUM_SRC-1:0] = status_q;
      A_NEST: begin
        reg_rdata[OVR_BIT]     = nest_ovr;
        reg_rdata[PRIO_W-1:0]  = nest_ovr ? nest_lvl : active_prio;
      end
      default: begin
        for (int i = 0; i < NUM_SRC; i++)
          if (reg_addr == ADDR_W'(PRIO_BASE + i))
            reg_rdata[PRIO_W-1:0] = prio_flat[i*PRIO_W +: PRIO_W];
      end
    endcase
  end
endmodule

// File: rtl/ing_checker.sv
module ing_checker
  import ing_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] sys_irq,
  input logic               reg_wr_en,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               host_irq,
  input logic               active_valid,
  input logic [IDX_W-1:0]   active_idx,
  input logic [PRIO_W-1:0]  active_prio,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] enable,
  input logic               override,
  input logic [PRIO_W-1:0]  sw_level,
  input logic               host_en
);
  logic [NUM_SRC-1:0] seen_q;
  logic [NUM_SRC-1:0] edge_now;
  logic [NUM_SRC-1:0] cand;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_q <= '0;
    else        seen_q <= sys_irq;

  assign edge_now = sys_irq & ~seen_q;
  assign cand     = status & enable;

  assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_now) & ~status) == '0));

  assert_mask_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == A_STATUS)
      |=> ((status & $past(reg_wdata[NUM_SRC-1:0] & ~edge_now)) == '0));

  assert_winner_is_cand_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active_valid |-> cand[active_idx]);

  assert_none_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active_valid |-> (cand == '0));

  assert_level_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && override) |-> (active_prio < sw_level));

  assert_host_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (host_en && active_valid));
endmodule

bind intr_nest_gate ing_checker #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_irq(sys_irq), .reg_wr_en(reg_wr_en),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .host_irq(host_irq),
  .active_valid(active_valid), .active_idx(active_idx),
  .active_prio(active_prio), .status(status_q), .enable(enable_q),
  .override(nest_ovr), .sw_level(nest_lvl), .host_en(host_en)
);

// File: tb/sim_intr_nest_gate.sv
module sim_intr_nest_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sys_irq = '0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        host_irq, active_valid;
  logic [2:0]  active_idx, active_prio;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intr_nest_gate u0 (
    .clk(clk), .rst_n(rst_n), .sys_irq(sys_irq), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .host_irq(host_irq), .active_valid(active_valid),
    .active_idx(active_idx), .active_prio(active_prio)
  );

  typedef struct packed {
    logic [7:0]  pulse;
    logic [7:0]  en;
    logic [15:0] nest;
    logic        vld;
    logic [2:0]  idx;
    logic        host;
    logic [15:0] nrd;
  } vec_t;

  // Priorities per source: 3 1 5 1 6 7 2 4
  localparam vec_t TBL [8] = '{
    '{8'h01, 8'hFF, 16'h0000, 1'b1, 3'd0, 1'b1, 16'h0003},
    '{8'h0B, 8'hFF, 16'h0000, 1'b1, 3'd1, 1'b1, 16'h0001},
    '{8'h0B, 8'hF9, 16'h0000, 1'b1, 3'd3, 1'b1, 16'h0001},
    '{8'h41, 8'hFF, 16'h8002, 1'b1, 3'd6, 1'b0, 16'h8002},
    '{8'h41, 8'hFF, 16'h8003, 1'b1, 3'd6, 1'b1, 16'h8003},
    '{8'hFF, 8'h00, 16'h0000, 1'b0, 3'd0, 1'b0, 16'h0007},
    '{8'h10, 8'hFF, 16'h8007, 1'b1, 3'd4, 1'b1, 16'h8007},
    '{8'h10, 8'hFF, 16'h8000, 1'b1, 3'd4, 1'b0, 16'h8000}
  };

  function automatic logic [2:0] prio_of(int i);
    case (i)
      0: return 3'd3; 1: return 3'd1; 2: return 3'd5; 3: return 3'd1;
      4: return 3'd6; 5: return 3'd7; 6: return 3'd2; default: return 3'd4;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(logic [7:0] m);
    @(negedge clk); sys_irq = m;
    @(negedge clk); sys_irq = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 host", {15'd0, host_irq}, 16'd0);
    check("R10 valid", {15'd0, active_valid}, 16'd0);
    rd(5'd2, v); check("R10 status", v, 16'h0000);
    rd(5'd1, v); check("R10 enable", v, 16'h0000);
    rd(5'd0, v); check("R10 ctrl", v, 16'h0000);
    rd(5'd4, v); check("R7 idle nest read", v, 16'h0007);

    for (int i = 0; i < 8; i++) wr(5'(8 + i), {13'd0, prio_of(i)});
    rd(5'd10, v); check("R6 prio readback", v, 16'h0005);
    wr(5'd0, 16'h0001);

    foreach (TBL[k]) begin
      wr(5'd2, 16'h00FF);
      wr(5'd1, {8'd0, TBL[k].en});
      wr(5'd4, TBL[k].nest);
      pulse(TBL[k].pulse);
      check($sformatf("R6 valid row %0d", k), {15'd0, active_valid}, {15'd0, TBL[k].vld});
      check($sformatf("R6 idx row %0d", k), {13'd0, active_idx}, {13'd0, TBL[k].idx});
      check($sformatf("R8 host row %0d", k), {15'd0, host_irq}, {15'd0, TBL[k].host});
      rd(5'd4, v); check($sformatf("R7 nest read row %0d", k), v, TBL[k].nrd);
    end

    // R9 host enable masks without losing status (bit4 pending)
    wr(5'd4, 16'h0000);
    check("R8 override cleared host", {15'd0, host_irq}, 16'd1);
    wr(5'd0, 16'h0000);
    check("R9 masked host", {15'd0, host_irq}, 16'd0);
    rd(5'd2, v); check("R9 status kept", v, 16'h0010);
    wr(5'd0, 16'h0001);
    check("R9 host restored", {15'd0, host_irq}, 16'd1);

    // R3 index clear and out-of-range index
    wr(5'd3, 16'd4);
    rd(5'd2, v); check("R3 index clear", v, 16'h0000);
    check("R3 host drops", {15'd0, host_irq}, 16'd0);
    pulse(8'h20);
    wr(5'd3, 16'd9);
    rd(5'd2, v); check("R3 out of range ignored", v, 16'h0020);

    // R2 zero bits do nothing, one bits clear
    wr(5'd2, 16'h0000);
    rd(5'd2, v); check("R2 zero write", v, 16'h0020);
    wr(5'd2, 16'h0020);
    rd(5'd2, v); check("R2 one write", v, 16'h0000);

    // R4 clear and new edge in the same cycle
    @(negedge clk);
    sys_irq = 8'h04; reg_wr_en = 1'b1; reg_addr = 5'd2; reg_wdata = 16'h0004;
    @(negedge clk);
    reg_wr_en = 1'b0; sys_irq = 8'h00;
    rd(5'd2, v); check("R4 edge beats clear", v, 16'h0004);

    // R5 disabling keeps status
    wr(5'd1, 16'h00FB);
    check("R5 disabled not candidate", {15'd0, active_valid}, 16'd0);
    rd(5'd2, v); check("R5 status kept", v, 16'h0004);
    wr(5'd1, 16'h00FF);
    check("R5 reenabled idx", {13'd0, active_idx}, 16'd2);
    check("R6 prio of winner", {13'd0, active_prio}, 16'd5);

    // R1 held line does not re-set after clear
    wr(5'd2, 16'h00FF);
    @(negedge clk); sys_irq = 8'h01;
    @(negedge clk);
    rd(5'd2, v); check("R1 edge sets", v, 16'h0001);
    wr(5'd2, 16'h0001);
    repeat (3) @(negedge clk);
    rd(5'd2, v); check("R1 held line no reset", v, 16'h0000);
    sys_irq = 8'h00;

    done = 1'b1;
    finish_run();
  end
endmodule